// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes a data word between two ports, A and B, in either direction. Each direction has its own bank of storage, so a word travelling from A to B and a word travelling from B to A are held separately. Three active-low controls govern each direction: a direction enable, a latch enable and an output enable. While both the direction enable and the latch enable are low, the bank is transparent and the far port follows the near port. When either of them goes high, the bank stops following and keeps the last word it took in.

Each port is presented as a data vector plus a drive-enable bit that stands for the tri-state buffer. A drive-enable of 0 means the port is high-impedance. Surrounding code can merge the two into an inout pad if it needs one. The storage is synchronous to `clk`, so a control edge takes effect at the next rising clock edge. An asynchronous active-low reset clears both banks and forces both ports to high-impedance.

Top module: `latched_xcvr`

## Requirements
- R1: The two banks are independent: activity on the B-to-A controls and on `bIn` never changes the word held for A-to-B, and activity on the A-to-B controls and on `aIn` never changes the word held for B-to-A.
- R2: Every control is active-low. `bDriveEn` is 1 exactly when reset is released, `enAbN` = 0 and `oeAbN` = 0. In every other case it is 0, meaning B is high-impedance.
- R3: While `enAbN` = 0 and `latchAbN` = 0, `bOut` equals `aIn` in the same cycle, with no clock delay.
- R4: When `latchAbN` rises, the A-to-B bank keeps the `aIn` value sampled at the last rising clock edge at which the bank was still open.
- R5: A rise of `enAbN` captures data in the same way as a rise of `latchAbN`. When `enAbN` returns low with `latchAbN` high, `bOut` shows the captured word.
- R6: While `enAbN` or `latchAbN` is high, changes on `aIn` have no effect on `bOut`.
- R7: The bank can load and capture data while `oeAbN` = 1 (outputs disabled). Once `oeAbN` goes low, the stored word appears on `bOut`.
- R8: The B-to-A direction follows R2 to R7 using `enBaN`, `latchBaN`, `oeBaN`, `bIn`, `aOut` and `aDriveEn`.
- R9: While `rstN` = 0, `aDriveEn` and `bDriveEn` are both 0. Both banks hold 0 after reset, and that 0 is what a closed bank shows once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage banks |
| rstN | input | 1 | Asynchronous active-low reset |
| enAbN | input | 1 | A-to-B direction enable, active-low |
| latchAbN | input | 1 | A-to-B latch enable, active-low |
| oeAbN | input | 1 | A-to-B output enable, active-low |
| enBaN | input | 1 | B-to-A direction enable, active-low |
| latchBaN | input | 1 | B-to-A latch enable, active-low |
| oeBaN | input | 1 | B-to-A output enable, active-low |
| aIn | input | DATA_W | Word arriving on port A |
| bIn | input | DATA_W | Word arriving on port B |
| aOut | output | DATA_W | Word presented on port A (from the B-to-A bank) |
| aDriveEn | output | 1 | Port A buffer enable; 0 means high-impedance |
| bOut | output | DATA_W | Word presented on port B (from the A-to-B bank) |
| bDriveEn | output | 1 | Port B buffer enable; 0 means high-impedance |

## Verification
The assertions take it for granted that the data and control inputs change only between rising clock edges and stay steady across each edge. They also assume that the system never enables both directions to drive at once, since that would be bus contention on a shared wire. The stimulus changes every input one nanosecond after a rising edge. Whenever a control pattern would turn on both drivers, it forces the B-to-A output enable high, so the contention check describes a legal system rather than a case the block has to resolve.

// File: rtl/latched_xcvr_pkg.sv
package latched_xcvr_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  // Per-direction strobes decoded from the active-low controls
  typedef struct packed {
    logic [NUM_DIR-1:0] gateOpen;  // bank follows its input
    logic [NUM_DIR-1:0] driveOn;   // far-side buffer enabled
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import latched_xcvr_pkg::*;
(
  input  logic               rstN,
  input  logic [NUM_DIR-1:0] enN,
  input  logic [NUM_DIR-1:0] latchN,
  input  logic [NUM_DIR-1:0] oeN,
  output xcvrStrobes_t       strobes
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    // Transparent only while both enable and latch enable are low
    assign strobes.gateOpen[d] = ~(enN[d] | latchN[d]);
    // Drive needs enable and output enable low, and reset released
    assign strobes.driveOn[d]  = rstN & ~(enN[d] | oeN[d]);
  end
endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gateOpen,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stored;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stored <= '0;
    else if (gateOpen) stored <= din;
  end

  // Open bank bypasses storage so the far side follows without delay
  assign dout = gateOpen ? din : stored;

  // R6
  hold_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(gateOpen)) |-> $stable(stored));

  // R4
  capture_on_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(gateOpen) && !gateOpen) |-> (dout == $past(din)));
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import latched_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  xcvrStrobes_t                   strobes,
  input  logic [NUM_DIR-1:0][DATA_W-1:0] dataIn,
  output logic [NUM_DIR-1:0][DATA_W-1:0] dataOut,
  output logic [NUM_DIR-1:0]             driveEn
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_bank
    xcvr_latch_bank #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .gateOpen(strobes.gateOpen[d]),
      .din     (dataIn[d]),
      .dout    (dataOut[d])
    );
    assign driveEn[d] = strobes.driveOn[d];
  end
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import latched_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enAbN,
  input  logic              latchAbN,
  input  logic              oeAbN,
  input  logic              enBaN,
  input  logic              latchBaN,
  input  logic              oeBaN,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aDriveEn,
  output logic [DATA_W-1:0] bOut,
  output logic              bDriveEn
);
  xcvrStrobes_t                   strobes;
  logic [NUM_DIR-1:0][DATA_W-1:0] dataIn;
  logic [NUM_DIR-1:0][DATA_W-1:0] dataOut;
  logic [NUM_DIR-1:0]             driveEn;

  xcvr_ctrl u_ctrl (
    .rstN   (rstN),
    .enN    ({enBaN, enAbN}),
    .latchN ({latchBaN, latchAbN}),
    .oeN    ({oeBaN, oeAbN}),
    .strobes(strobes)
  );

  assign dataIn[DIR_AB] = aIn;
  assign dataIn[DIR_BA] = bIn;

  xcvr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .driveEn(driveEn)
  );

  assign bOut     = dataOut[DIR_AB];
  assign bDriveEn = driveEn[DIR_AB];
  assign aOut     = dataOut[DIR_BA];
  assign aDriveEn = driveEn[DIR_BA];

  // R3
  ab_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enAbN && !latchAbN) |-> (bOut == aIn));

  // R8
  ba_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enBaN && !latchBaN) |-> (aOut == bIn));

  // R2
  ab_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enAbN || oeAbN) |-> !bDriveEn);

  // R8
  ba_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBaN || oeBaN) |-> !aDriveEn);

  // R2 (system assumption: one driver at a time)
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(aDriveEn && bDriveEn));

  // R9
  always_comb begin
    if (!rstN) begin
      reset_hiz_chk: assert (!aDriveEn && !bDriveEn);
    end
  end
endmodule

// File: tb/sim_latched_xcvr.sv
`timescale 1ns/1ps
module sim_latched_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enAbN = 1'b0, latchAbN = 1'b0, oeAbN = 1'b0;
  logic enBaN = 1'b1, latchBaN = 1'b1, oeBaN = 1'b1;
  logic [W-1:0] aIn = 8'h5A, bIn = 8'h00;
  logic [W-1:0] aOut, bOut;
  logic aDriveEn, bDriveEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R9";

  // Behavioural reference storage
  logic [W-1:0] refAb = '0, refBa = '0;

  always #10 clk = ~clk;

  latched_xcvr #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN),
    .enAbN(enAbN), .latchAbN(latchAbN), .oeAbN(oeAbN),
    .enBaN(enBaN), .latchBaN(latchBaN), .oeBaN(oeBaN),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aDriveEn(aDriveEn), .bOut(bOut), .bDriveEn(bDriveEn)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refAb <= '0;
      refBa <= '0;
    end else begin
      if (enAbN == 1'b0 && latchAbN == 1'b0) refAb <= aIn;
      if (enBaN == 1'b0 && latchBaN == 1'b0) refBa <= bIn;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  // Compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (!done) begin
      chk("bDriveEn", int'(bDriveEn), int'(rstN && !enAbN && !oeAbN));
      chk("aDriveEn", int'(aDriveEn), int'(rstN && !enBaN && !oeBaN));
      if (rstN) begin
        chk("bOut", int'(bOut), int'((!enAbN && !latchAbN) ? aIn : refAb));
        chk("aOut", int'(aOut), int'((!enBaN && !latchBaN) ? bIn : refBa));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual hung expected finished");
    finish_run();
  end

  initial begin
    // R9: drive enables held off through reset although AB controls are low
    step(3);
    rstN = 1'b1;
    // R3: transparent path
    curReq = "R3";
    aIn = 8'h11; step(1);
    aIn = 8'hA7; step(1);
    aIn = 8'hFF; step(1);
    aIn = 8'h3C; step(1);
    // R4: latch enable rises and captures 3C
    curReq = "R4";
    latchAbN = 1'b1; step(1);
    // R6: data changes are ignored while closed
    curReq = "R6";
    aIn = 8'h00; step(1);
    aIn = 8'h81; step(2);
    // R5: direction enable rises and captures C3
    curReq = "R5";
    latchAbN = 1'b0; aIn = 8'hC3; step(1);
    enAbN = 1'b1; step(1);
    aIn = 8'h0F; step(2);
    latchAbN = 1'b1; enAbN = 1'b0; step(2);
    // R7: load and capture while outputs disabled
    curReq = "R7";
    oeAbN = 1'b1; latchAbN = 1'b0; aIn = 8'h99; step(1);
    latchAbN = 1'b1; step(1);
    aIn = 8'h00; step(1);
    oeAbN = 1'b0; step(2);
    // R8: B-to-A direction with A-to-B output off
    curReq = "R8";
    oeAbN = 1'b1;
    enBaN = 1'b0; latchBaN = 1'b0; oeBaN = 1'b0;
    bIn = 8'h24; step(1);
    bIn = 8'h6E; step(1);
    latchBaN = 1'b1; step(1);
    bIn = 8'hE6; step(1);
    oeBaN = 1'b1; step(1);
    oeBaN = 1'b0; latchBaN = 1'b0; bIn = 8'h55; step(1);
    enBaN = 1'b1; step(1);
    bIn = 8'hAA; step(1);
    latchBaN = 1'b1; enBaN = 1'b0; step(1);
    // R1: B-to-A activity leaves A-to-B word (99) alone
    curReq = "R1";
    latchBaN = 1'b0; bIn = 8'h12; step(1);
    bIn = 8'h34; step(1);
    oeBaN = 1'b1; latchBaN = 1'b1; oeAbN = 1'b0; step(1);
    aIn = 8'h77; step(1);
    // R2: output enable toggling
    curReq = "R2";
    oeAbN = 1'b1; step(1);
    oeAbN = 1'b0; step(1);
    enAbN = 1'b1; step(1);
    enAbN = 1'b0; step(1);
    // Mixed patterns, keeping one driver at a time
    curReq = "R1";
    for (int i = 0; i < 400; i++) begin
      logic [5:0] c;
      c = 6'($urandom);
      enAbN = c[0]; latchAbN = c[1]; oeAbN = c[2];
      enBaN = c[3]; latchBaN = c[4]; oeBaN = c[5];
      if (!enAbN && !oeAbN && !enBaN) oeBaN = 1'b1;
      aIn = 8'($urandom);
      bIn = 8'($urandom);
      step(1);
    end
    // R9: reset again clears both banks
    curReq = "R9";
    rstN = 1'b0; step(2);
    enAbN = 1'b0; latchAbN = 1'b1; oeAbN = 1'b0;
    enBaN = 1'b1; latchBaN = 1'b1; oeBaN = 1'b1;
    rstN = 1'b1; step(2);
    oeAbN = 1'b1; enBaN = 1'b0; oeBaN = 1'b0; step(2);
    finish_run();
  end
endmodule